// File: doc/BRIEF.md
# Two-Clock Synchronous RAM with Separate Write and Read Ports

This block is a simple dual-port memory. One port only writes and the other only reads. Each port has its own clock. The storage is an asynchronous two-port array placed behind per-port input registers. On the rising edge of its own clock, each port captures its active-low enable and its address, and the write port also captures its data.

A write lands in the array on the falling edge of the write clock, so the write pulse fills the high phase of that clock. The read data is a combinational lookup of the array at the registered read address. When the same word is read and written at once, the read output moves to the new word as soon as that write lands. A test-only input, `arr_enable`, shuts the array off: writes are blocked and the read output becomes undefined. When a read is disabled, the output is also undefined and does not hold the previous word.

"Undefined" is modelled as a fixed poison word, so that two-state simulators can see it.

Top module: `dcram_2p`

## Requirements
- R1: Write enable, write address and write data are captured on the rising edge of `wclk`. Changes to these inputs after that edge have no effect on the write that was captured.
- R2: A captured write with `w_en_n` high (1) leaves every stored word unchanged.
- R3: Read enable and read address are captured on the rising edge of `rclk`. Changing `r_addr` between edges does not change `r_data`.
- R4: While the captured `r_en_n` is low (0), `r_data` equals the word stored at the captured read address. It is valid as soon as the capture edge has passed.
- R5: While the captured `r_en_n` is high, `r_data` shows the poison word. In the poison word, bit i is 1 when i is odd and 0 when i is even (0xAAAA for 16 bits). The previous read data is not held.
- R6: A write commits on the falling edge of `wclk` that follows its capture edge. If the read port holds the same address, `r_data` shows the old word until that falling edge and the new word from then on.
- R7: Every address from 0 to DEPTH-1 stores and returns its own WIDTH-bit word independently of the other addresses.
- R8: While `arr_enable` is low, `r_data` shows the poison word whatever the read enable is. This takes effect without waiting for a clock edge.
- R9: A write that commits while `arr_enable` is low does not change the array. The old word reads back after `arr_enable` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| w_en_n | input | 1 | Write enable, active low, captured on `wclk` rise |
| w_addr | input | $clog2(DEPTH) | Write address |
| w_data | input | WIDTH | Write data |
| rclk | input | 1 | Read-port clock |
| r_en_n | input | 1 | Read enable, active low, captured on `rclk` rise |
| r_addr | input | $clog2(DEPTH) | Read address |
| r_data | output | WIDTH | Read data, or the poison word when disabled |
| arr_enable | input | 1 | Test-only array enable; hold high in normal use |

## Verification
The bench aims at the same-address case first. It checks the read output both before and after the falling edge of the write clock. A design that committed on the rising edge, or that latched the read output, would show the new word too early or never show it. Write inputs are scrambled straight after their capture edge, and the read address is moved between read edges. Either check exposes a design that uses live inputs instead of captured ones. Disabled reads and the array-off input must produce the poison word, and a write made while the array is off must leave the old word in place once the array is back on.

// File: rtl/dcram_pkg.sv
package dcram_pkg;

    localparam int MAX_W = 256;

    // Poison pattern: odd bit positions set, even bit positions clear.
    function automatic logic [MAX_W-1:0] odd_stripe();
        logic [MAX_W-1:0] v;
        for (int i = 0; i < MAX_W; i++) begin
            v[i] = (i % 2) == 1;
        end
        return v;
    endfunction

    typedef enum logic {
        ARR_OFF = 1'b0,
        ARR_ON  = 1'b1
    } arr_state_e;

endpackage

// File: rtl/dcram_wport.sv
module dcram_wport #(
    parameter int WIDTH = 16,
    parameter int AW    = 5
) (
    input  logic             clk,
    input  logic             en_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] data,
    output logic             q_en_n,
    output logic [AW-1:0]    q_addr,
    output logic [WIDTH-1:0] q_data
);
    typedef struct packed {
        logic             en_n;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
    } wreg_t;

    wreg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en_n = en_n;
        st_d.addr = addr;
        st_d.data = data;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_en_n = st_q.en_n;
    assign q_addr = st_q.addr;
    assign q_data = st_q.data;
endmodule

// File: rtl/dcram_rport.sv
module dcram_rport #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          en_n,
    input  logic [AW-1:0] addr,
    output logic          q_en_n,
    output logic [AW-1:0] q_addr
);
    typedef struct packed {
        logic          en_n;
        logic [AW-1:0] addr;
    } rreg_t;

    rreg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en_n = en_n;
        st_d.addr = addr;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_en_n = st_q.en_n;
    assign q_addr = st_q.addr;
endmodule

// File: rtl/dcram_array.sv
module dcram_array
    import dcram_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic             wclk,
    input  logic             arr_enable,
    input  logic             wq_en_n,
    input  logic [AW-1:0]    wq_addr,
    input  logic [WIDTH-1:0] wq_data,
    input  logic             rq_en_n,
    input  logic [AW-1:0]    rq_addr,
    output logic [WIDTH-1:0] r_data
);
    localparam logic [WIDTH-1:0] POISON = WIDTH'(odd_stripe());
    localparam bit FULL_MAP = (DEPTH == (1 << AW));

    logic [WIDTH-1:0] mem [DEPTH];
    logic             w_in_range;
    logic             r_in_range;
    arr_state_e       arr_st;

    assign arr_st = arr_enable ? ARR_ON : ARR_OFF;

    // Address range guard only exists when DEPTH is not a power of two.
    generate
        if (FULL_MAP) begin : g_full
            assign w_in_range = 1'b1;
            assign r_in_range = 1'b1;
        end else begin : g_part
            assign w_in_range = (32'(wq_addr) < DEPTH);
            assign r_in_range = (32'(rq_addr) < DEPTH);
        end
    endgenerate

    // Write pulse spans the clock-high phase; the word lands on the fall.
    always_ff @(negedge wclk) begin
        if (!wq_en_n && (arr_st == ARR_ON) && w_in_range) begin
            mem[wq_addr] <= wq_data;
        end
    end

    always_comb begin
        if ((arr_st == ARR_OFF) || rq_en_n || !r_in_range) begin
            r_data = POISON;
        end else begin
            r_data = mem[rq_addr];
        end
    end
endmodule

// File: rtl/dcram_2p.sv
module dcram_2p #(
    parameter  int WIDTH = 16,
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             w_en_n,
    input  logic [AW-1:0]    w_addr,
    input  logic [WIDTH-1:0] w_data,
    input  logic             rclk,
    input  logic             r_en_n,
    input  logic [AW-1:0]    r_addr,
    output logic [WIDTH-1:0] r_data,
    input  logic             arr_enable
);
    logic             wq_en_n;
    logic [AW-1:0]    wq_addr;
    logic [WIDTH-1:0] wq_data;
    logic             rq_en_n;
    logic [AW-1:0]    rq_addr;

    dcram_wport #(.WIDTH(WIDTH), .AW(AW)) u_wport (
        .clk    (wclk),
        .en_n   (w_en_n),
        .addr   (w_addr),
        .data   (w_data),
        .q_en_n (wq_en_n),
        .q_addr (wq_addr),
        .q_data (wq_data)
    );

    dcram_rport #(.AW(AW)) u_rport (
        .clk    (rclk),
        .en_n   (r_en_n),
        .addr   (r_addr),
        .q_en_n (rq_en_n),
        .q_addr (rq_addr)
    );

    dcram_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_array (
        .wclk       (wclk),
        .arr_enable (arr_enable),
        .wq_en_n    (wq_en_n),
        .wq_addr    (wq_addr),
        .wq_data    (wq_data),
        .rq_en_n    (rq_en_n),
        .rq_addr    (rq_addr),
        .r_data     (r_data)
    );
endmodule

// File: rtl/dcram_2p_chk.sv
module dcram_2p_chk
    import dcram_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 5
) (
    input logic             wclk,
    input logic             rclk,
    input logic             w_en_n,
    input logic [AW-1:0]    w_addr,
    input logic [WIDTH-1:0] w_data,
    input logic             r_en_n,
    input logic [AW-1:0]    r_addr,
    input logic [WIDTH-1:0] r_data,
    input logic             arr_enable,
    input logic             wq_en_n,
    input logic [AW-1:0]    wq_addr,
    input logic [WIDTH-1:0] wq_data,
    input logic             rq_en_n,
    input logic [AW-1:0]    rq_addr
);
    localparam logic [WIDTH-1:0] POISON = WIDTH'(odd_stripe());

    logic w_armed = 1'b0;
    logic r_armed = 1'b0;

    always_ff @(posedge wclk) w_armed <= 1'b1;
    always_ff @(posedge rclk) r_armed <= 1'b1;

    a_r1_write_capture: assert property (@(posedge wclk) disable iff (!w_armed)
        w_armed |=> (wq_en_n == $past(w_en_n) && wq_addr == $past(w_addr)
                     && wq_data == $past(w_data)));

    a_r3_read_capture: assert property (@(posedge rclk) disable iff (!r_armed)
        r_armed |=> (rq_en_n == $past(r_en_n) && rq_addr == $past(r_addr)));

    a_r5_poison_when_read_off: assert property (@(posedge rclk) disable iff (!r_armed)
        rq_en_n |-> (r_data == POISON));

    a_r8_poison_when_array_off: assert property (@(posedge wclk) disable iff (!r_armed)
        !arr_enable |-> (r_data == POISON));
endmodule

bind dcram_2p dcram_2p_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .wclk       (wclk),
    .rclk       (rclk),
    .w_en_n     (w_en_n),
    .w_addr     (w_addr),
    .w_data     (w_data),
    .r_en_n     (r_en_n),
    .r_addr     (r_addr),
    .r_data     (r_data),
    .arr_enable (arr_enable),
    .wq_en_n    (wq_en_n),
    .wq_addr    (wq_addr),
    .wq_data    (wq_data),
    .rq_en_n    (rq_en_n),
    .rq_addr    (rq_addr)
);

// File: tb/tb_dcram_2p.sv
`timescale 1ns/100ps
module tb_dcram_2p;
    localparam int W  = 16;
    localparam int D  = 32;
    localparam int AW = 5;
    localparam logic [W-1:0] POISON = 16'hAAAA;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          w_en_n = 1'b1;
    logic [AW-1:0] w_addr = '0;
    logic [W-1:0]  w_data = '0;
    logic          r_en_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [W-1:0]  r_data;
    logic          arr_enable = 1'b1;

    logic [W-1:0] shadow [D];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcram_2p #(.WIDTH(W), .DEPTH(D)) dut (
        .wclk, .w_en_n, .w_addr, .w_data,
        .rclk, .r_en_n, .r_addr, .r_data, .arr_enable
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_word(input int a, input logic [W-1:0] d, input bit upd);
        @(posedge wclk); #0.5;
        w_en_n = 1'b0; w_addr = AW'(a); w_data = d;
        @(posedge wclk); #0.5;
        w_en_n = 1'b1; w_addr = ~AW'(a); w_data = ~d;   // scramble after capture
        @(negedge wclk); #0.5;
        if (upd) shadow[a] = d;
    endtask

    task automatic read_word(input int a, output logic [W-1:0] v);
        @(posedge rclk); #0.5;
        r_en_n = 1'b0; r_addr = AW'(a);
        @(posedge rclk); #0.5;
        v = r_data;
    endtask

    task automatic t_idle_state();
        logic [W-1:0] v;
        @(posedge rclk); @(posedge rclk); #0.5;
        v = r_data;
        check("R5 read disabled after start", v, POISON);
    endtask

    task automatic t_sweep();
        logic [W-1:0] v;
        for (int a = 0; a < D; a++) begin
            logic [W-1:0] d;
            d = W'(a * 16'h0407) ^ 16'h1C3B;
            if (d == POISON) d = d ^ 16'h0001;
            write_word(a, d, 1'b1);
        end
        for (int a = D - 1; a >= 0; a--) begin
            read_word(a, v);
            check($sformatf("R7/R4 sweep addr %0d", a), v, shadow[a]);
        end
    endtask

    task automatic t_write_capture();
        logic [W-1:0] v;
        write_word(5, 16'h3C5A, 1'b1);      // inputs scrambled to addr 26 / 0xC3A5
        read_word(5, v);
        check("R1 captured data written", v, 16'h3C5A);
        read_word(26, v);
        check("R1 scrambled address untouched", v, shadow[26]);
    endtask

    task automatic t_write_disabled();
        logic [W-1:0] v;
        @(posedge wclk); #0.5;
        w_en_n = 1'b1; w_addr = AW'(9); w_data = 16'h7777;
        @(posedge wclk); @(negedge wclk); #0.5;
        read_word(9, v);
        check("R2 disabled write ignored", v, shadow[9]);
    endtask

    task automatic t_read_capture();
        logic [W-1:0] v;
        read_word(3, v);
        check("R4 read addr 3", v, shadow[3]);
        r_addr = AW'(4);                 // move address between edges
        #2.0;
        check("R3 output holds captured address", r_data, shadow[3]);
        @(posedge rclk); #0.5;
        check("R3 new address after edge", r_data, shadow[4]);
    endtask

    task automatic t_read_off();
        logic [W-1:0] v;
        read_word(7, v);
        check("R4 read before disable", v, shadow[7]);
        @(posedge rclk); #0.5;
        r_en_n = 1'b1;
        @(posedge rclk); #0.5;
        check("R5 poison when read disabled", r_data, POISON);
        r_en_n = 1'b0;
    endtask

    task automatic t_collision();
        logic [W-1:0] v;
        logic [W-1:0] old_w;
        read_word(12, v);
        old_w = shadow[12];
        check("R4 collision setup", v, old_w);
        @(posedge wclk); #0.5;
        w_en_n = 1'b0; w_addr = AW'(12); w_data = 16'h5E17;
        @(posedge wclk); #0.5;
        w_en_n = 1'b1;
        check("R6 old word before falling edge", r_data, old_w);
        @(negedge wclk); #0.5;
        check("R6 new word after falling edge", r_data, 16'h5E17);
        shadow[12] = 16'h5E17;
    endtask

    task automatic t_array_off();
        logic [W-1:0] v;
        read_word(20, v);
        check("R4 read before array off", v, shadow[20]);
        arr_enable = 1'b0;
        #0.5;
        check("R8 poison while array off", r_data, POISON);
        write_word(20, 16'h0F0F, 1'b0);
        check("R8 poison still while off", r_data, POISON);
        arr_enable = 1'b1;
        #0.5;
        check("R9 write blocked while off", r_data, shadow[20]);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_idle_state();
        t_sweep();
        t_write_capture();
        t_write_disabled();
        t_read_capture();
        t_read_off();
        t_collision();
        t_array_off();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule